// File: doc/BRIEF.md
# Dual-Enable Asynchronous SRAM Model

This block is a synthesizable stand-in for a byte-wide static memory with a pin-style asynchronous interface. A fast clock samples the pins. The block decodes two chip selects of opposite polarity, an active-low output enable and an active-low write enable into one of five modes: standby caused by the low-active select, standby caused by the high-active select, read, write, and selected-but-quiet. Tri-state pins are represented by a data output bus plus a drive flag. A separate flag reports the low-power standby state.

A write follows level-sensitive overlap semantics. The write window is open while the low-active select is low, the high-active select is high and write enable is low. Whichever of the three signals closes the window commits the byte. The byte and address committed are those from the last sample taken inside the window.

The address port is `ADDR_W` (17) bits wide and the data port is `DATA_W` (8) bits wide. The physical storage holds `2**STORE_W` bytes. When `STORE_W` is below `ADDR_W`, addresses alias modulo that depth. A full-size instance sets `STORE_W = ADDR_W`. Contents are undefined until written.

Top module: `sram_model`

## Requirements
- R1: When `sel_n` is 1 or `sel` is 0 at a sample, `standby` is 1 and `q_en` is 0 from the second clock edge after that sample onwards. The low-active select takes priority when both are inactive.
- R2: With `sel_n`=0, `sel`=1, `wr_n`=1 and `oe_n`=0, `q_en` becomes 1 two edges after the sample, and `q` then shows the stored byte at `addr`. Whenever `q_en` is 0, `q` is all zeros.
- R3: With the device selected and both `wr_n` and `oe_n` at 1, `q_en` is 0 and `standby` is 0.
- R4: With the device selected and `wr_n`=0, `q_en` is 0 and `standby` is 0 whatever the value of `oe_n`.
- R5: A write is committed when the overlap window closes. The window can be closed by `wr_n` rising, by `sel_n` rising or by `sel` falling. The data seen on the sample where the window is already closed is not stored.
- R6: If `din` changes while the window is open, the value from the last sample inside the window is stored.
- R7: If a select deasserts on the same sample that `wr_n` rises, while `oe_n` stays 0, `q_en` stays 0 on every following cycle.
- R8: While `rst_n` is 0 at a clock edge, `q_en` is 0, `standby` is 1 and `q` is zero after that edge.
- R9: Stimulus outside an open window never changes storage. This covers `wr_n`=0 while deselected and any `din` activity during read or quiet modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the pins |
| q | output | DATA_W | Read data, zero when not driving |
| q_en | output | 1 | High when the data pins would be driven |
| standby | output | 1 | High in the deselected low-power state |

## Verification
The checker verifies the mode mapping on every cycle. It confirms that the drive and standby flags match the pins sampled two edges earlier, that the two flags are never both high, that the bus is zero when not driving, and that reset forces standby. What storage holds is invisible to those properties. Commit on each of the three closing signals, the last-sample-wins rule, rejection of writes while deselected, and the absence of drive when a select and write enable release together can only be shown by the bench, which writes and then reads back.

// File: rtl/sram_pkg.sv
// Shared types for the sampled SRAM model.
// Assumes: nothing; pure type definitions.
package sram_pkg;
    typedef enum logic [2:0] {
        MODE_OFF_LO = 3'd0,   // deselected by the low-active select
        MODE_OFF_HI = 3'd1,   // deselected by the high-active select
        MODE_READ   = 3'd2,
        MODE_WRITE  = 3'd3,
        MODE_QUIET  = 3'd4    // selected, outputs floating
    } sram_mode_e;
endpackage

// File: rtl/sram_pin_sampler.sv
// Registers every interface pin once per sampling clock.
// Assumes: pins are already synchronous to clk or held for two or more samples.
// Reset values describe a deselected, idle interface.
module sram_pin_sampler #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              sel_n_s,
    output logic              sel_s,
    output logic              oe_n_s,
    output logic              wr_n_s,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DATA_W-1:0] din_s
);
    // Capture the pin state, forcing the deselected state during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_n_s <= 1'b1;
            sel_s   <= 1'b0;
            oe_n_s  <= 1'b1;
            wr_n_s  <= 1'b1;
            addr_s  <= '0;
            din_s   <= '0;
        end else begin
            sel_n_s <= sel_n;
            sel_s   <= sel;
            oe_n_s  <= oe_n;
            wr_n_s  <= wr_n;
            addr_s  <= addr;
            din_s   <= din;
        end
    end
endmodule

// File: rtl/sram_mode_decode.sv
// Maps the sampled control pins onto one of five operating modes.
// Assumes: inputs come from the pin sampler, so the decode is glitch-free per cycle.
module sram_mode_decode
    import sram_pkg::*;
(
    input  logic       sel_n_s,
    input  logic       sel_s,
    input  logic       oe_n_s,
    input  logic       wr_n_s,
    output sram_mode_e mode
);
    // Priority: low-active select, high-active select, write, read, quiet.
    always_comb begin
        if (sel_n_s)      mode = MODE_OFF_LO;
        else if (!sel_s)  mode = MODE_OFF_HI;
        else if (!wr_n_s) mode = MODE_WRITE;
        else if (!oe_n_s) mode = MODE_READ;
        else              mode = MODE_QUIET;
    end
endmodule

// File: rtl/sram_write_ctrl.sv
// Tracks the write overlap window and emits one commit when it closes.
// Assumes: mode is decoded from registered pins. The committed address and data
// are the last ones seen while the window was open.
module sram_write_ctrl
    import sram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sram_mode_e        mode,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] din_s,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);
    logic win_now;
    logic win_last;

    assign win_now = (mode == MODE_WRITE);

    // Remember whether the window was open on the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) win_last <= 1'b0;
        else        win_last <= win_now;
    end

    // Hold address and data from each sample inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_addr <= '0;
            commit_data <= '0;
        end else if (win_now) begin
            commit_addr <= addr_s;
            commit_data <= din_s;
        end
    end

    // Commit exactly on the open-to-closed transition of the window.
    assign commit = win_last && !win_now;
endmodule

// File: rtl/sram_array.sv
// Byte storage with one write port and a registered, zero-when-idle read port.
// Assumes: STORE_W <= ADDR_W; upper address bits alias. Contents are not reset.
module sram_array #(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int STORE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << STORE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the committed byte.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr[STORE_W-1:0]] <= wr_data;
    end

    // Present the addressed byte when reading, zeros otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr[STORE_W-1:0]];
        else            rd_data <= '0;
    end
endmodule

// File: rtl/sram_model.sv
// Top of the sampled dual-select static memory model.
// Assumes: clk is much faster than pin activity. Outputs follow the pins
// two sampling edges later. q_en stands in for tri-state drive.
module sram_model
    import sram_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int STORE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q,
    output logic              q_en,
    output logic              standby
);
    logic              sel_n_s, sel_s, oe_n_s, wr_n_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    sram_mode_e        mode;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;

    sram_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
        .clk(clk), .rst_n(rst_n),
        .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .wr_n(wr_n),
        .addr(addr), .din(din),
        .sel_n_s(sel_n_s), .sel_s(sel_s), .oe_n_s(oe_n_s), .wr_n_s(wr_n_s),
        .addr_s(addr_s), .din_s(din_s)
    );

    sram_mode_decode u_decode (
        .sel_n_s(sel_n_s), .sel_s(sel_s), .oe_n_s(oe_n_s), .wr_n_s(wr_n_s),
        .mode(mode)
    );

    sram_write_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .addr_s(addr_s), .din_s(din_s),
        .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
    );

    sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_W(STORE_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit), .wr_addr(commit_addr), .wr_data(commit_data),
        .rd_en(mode == MODE_READ), .rd_addr(addr_s), .rd_data(q)
    );

    // Register drive and standby flags in step with the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_en    <= 1'b0;
            standby <= 1'b1;
        end else begin
            q_en    <= (mode == MODE_READ);
            standby <= (mode == MODE_OFF_LO) || (mode == MODE_OFF_HI);
        end
    end
endmodule

// File: rtl/sram_model_chk.sv
// Port-level protocol checker for sram_model, attached by bind.
// Assumes: outputs lag the pins by two sampling edges.
module sram_model_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              sel,
    input logic              oe_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] q,
    input logic              q_en,
    input logic              standby
);
    // R1
    standby_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (standby == $past(sel_n || !sel, 2)));

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(!sel_n && sel && wr_n && !oe_n, 2)) |-> q_en);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_en |-> (q == '0));

    // R3
    quiet_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(!sel_n && sel && wr_n && oe_n, 2)) |-> (!q_en && !standby));

    // R4
    write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(!sel_n && sel && !wr_n, 2)) |-> (!q_en && !standby));

    // R1
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q_en, standby}));

    // R8
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!q_en && standby && q == '0));

    // R7
    no_late_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(sel_n || !sel, 2)) |-> !q_en);

    logic unused_ok;
    assign unused_ok = ^{addr, din};
endmodule

bind sram_model sram_model_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .wr_n(wr_n),
    .addr(addr), .din(din), .q(q), .q_en(q_en), .standby(standby)
);

// File: tb/sram_model_bench.sv
module sram_model_bench;
    localparam int AW = 17;
    localparam int DW = 8;

    typedef struct packed {
        logic          c_sel_n;
        logic          c_sel;
        logic          c_oe_n;
        logic          c_wr_n;
        logic [AW-1:0] c_addr;
        logic [DW-1:0] c_din;
        logic          x_en;
        logic          x_sb;
        logic [DW-1:0] x_q;
        logic [3:0]    req;
    } vec_t;

    // Each vector is held for three samples, then the outputs are checked.
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 1'b1, 17'd5,     8'h00, 1'b0, 1'b1, 8'h00, 4'd1}, // R1 low select off
        '{1'b0, 1'b0, 1'b0, 1'b1, 17'd5,     8'h00, 1'b0, 1'b1, 8'h00, 4'd1}, // R1 high select off
        '{1'b0, 1'b1, 1'b0, 1'b0, 17'd5,     8'hA5, 1'b0, 1'b0, 8'h00, 4'd4}, // R4 write, oe low
        '{1'b0, 1'b1, 1'b1, 1'b1, 17'd5,     8'h5A, 1'b0, 1'b0, 8'h00, 4'd3}, // R3 quiet, ends by wr
        '{1'b0, 1'b1, 1'b0, 1'b1, 17'd5,     8'h00, 1'b1, 1'b0, 8'hA5, 4'd5}, // R5 read back
        '{1'b0, 1'b1, 1'b1, 1'b0, 17'd9,     8'h3C, 1'b0, 1'b0, 8'h00, 4'd4}, // R4 write, oe high
        '{1'b1, 1'b1, 1'b1, 1'b0, 17'd9,     8'hC3, 1'b0, 1'b1, 8'h00, 4'd5}, // R5 ends by low select
        '{1'b0, 1'b1, 1'b0, 1'b1, 17'd9,     8'h00, 1'b1, 1'b0, 8'h3C, 4'd5}, // R5 read back
        '{1'b0, 1'b1, 1'b1, 1'b0, 17'h3FF,   8'h81, 1'b0, 1'b0, 8'h00, 4'd4}, // R4 write
        '{1'b0, 1'b0, 1'b1, 1'b0, 17'h3FF,   8'h18, 1'b0, 1'b1, 8'h00, 4'd5}, // R5 ends by high select
        '{1'b0, 1'b1, 1'b0, 1'b1, 17'h3FF,   8'h00, 1'b1, 1'b0, 8'h81, 4'd5}, // R5 read back
        '{1'b1, 1'b1, 1'b1, 1'b0, 17'd5,     8'hFF, 1'b0, 1'b1, 8'h00, 4'd9}, // R9 write while off
        '{1'b0, 1'b1, 1'b1, 1'b1, 17'd5,     8'hEE, 1'b0, 1'b0, 8'h00, 4'd3}, // R3 quiet
        '{1'b0, 1'b1, 1'b0, 1'b1, 17'd5,     8'h00, 1'b1, 1'b0, 8'hA5, 4'd9}  // R9 unchanged
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1, sel = 1'b0, oe_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] q;
    logic          q_en, standby;
    int            n_run = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    sram_model u_sram_model (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .wr_n(wr_n),
        .addr(addr), .din(din), .q(q), .q_en(q_en), .standby(standby)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic a_sel_n, input logic a_sel, input logic a_oe_n, input logic a_wr_n,
                         input logic [AW-1:0] a_addr, input logic [DW-1:0] a_din);
        sel_n = a_sel_n; sel = a_sel; oe_n = a_oe_n; wr_n = a_wr_n; addr = a_addr; din = a_din;
    endtask

    initial begin
        // R8: reset with a read pattern on the pins
        drive(1'b0, 1'b1, 1'b0, 1'b1, 17'd0, 8'h00);
        repeat (4) @(negedge clk);
        chk("R8", "q_en", {15'd0, q_en}, 16'd0);
        chk("R8", "standby", {15'd0, standby}, 16'd1);
        chk("R8", "q", {8'd0, q}, 16'd0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 17'd0, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].c_sel_n, VECS[i].c_sel, VECS[i].c_oe_n, VECS[i].c_wr_n,
                  VECS[i].c_addr, VECS[i].c_din);
            repeat (3) @(negedge clk);
            chk($sformatf("R%0d", VECS[i].req), "q_en", {15'd0, q_en}, {15'd0, VECS[i].x_en});
            chk($sformatf("R%0d", VECS[i].req), "standby", {15'd0, standby}, {15'd0, VECS[i].x_sb});
            chk($sformatf("R%0d", VECS[i].req), "q", {8'd0, q}, {8'd0, VECS[i].x_q});
        end

        // R6: data changes inside the window; the last sampled value is stored
        drive(1'b0, 1'b1, 1'b1, 1'b0, 17'd20, 8'h11);
        repeat (2) @(negedge clk);
        din = 8'h77;
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 17'd20, 8'h99);
        repeat (2) @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 17'd20, 8'h00);
        repeat (3) @(negedge clk);
        chk("R6", "q", {8'd0, q}, 16'h0077);

        // R7: select and write enable release together with oe low
        drive(1'b0, 1'b1, 1'b0, 1'b0, 17'd30, 8'h44);
        repeat (3) @(negedge clk);
        chk("R4", "q_en", {15'd0, q_en}, 16'd0);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 17'd30, 8'h00);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R7", "q_en", {15'd0, q_en}, 16'd0);
        end
        drive(1'b0, 1'b1, 1'b0, 1'b1, 17'd30, 8'h00);
        repeat (3) @(negedge clk);
        chk("R7", "q", {8'd0, q}, 16'h0044);
        chk("R2", "q_en", {15'd0, q_en}, 16'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule